// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a memory access that has already been translated to a page may go ahead. The page-walk logic supplies three permission bits gathered along the walk: user, writable and no-execute. It also supplies the 4-bit protection key of the last entry. The requester supplies the kind of access, its privilege, the relevant control flags and a 32-bit register of per-key rights.

The block combines four rule sets into one result: the user/supervisor rule, the write-protect rule, the execute rule (no-execute and supervisor-fetch-from-user-page prevention), and the per-key access-disable and write-disable rule. The result is the final read, write and execute rights, a general fault flag, and a separate flag for denials that come only from the key rights.

Every request marked valid is evaluated in one cycle. The result appears on registered outputs on the following clock edge, qualified by `out_valid`.

Top module: `page_perm_check`

## Requirements
- R1: A request sampled with `in_valid` high produces its result on the outputs after the next rising clock edge, with `out_valid` high for exactly that cycle; a synchronous active-high reset drives every output to 0.
- R2: A user-mode access (`acc_from_user`=1) to a page whose user bit is clear gives fault=1, all three rights 0 and key_fault=0, whatever the other inputs are.
- R3: Outside R2, read is granted unless the protection-key access-disable bit of R7 removes it.
- R4: Outside R2, the base write right is granted when the page is writable, or when a supervisor access sees write-protect (`ctl_wp`) clear.
- R5: Outside R2, execute is granted only when no-execute is clear; for a supervisor access to a user page with `ctl_smep`=1, execute is denied.
- R6: The key rules of R7 and R8 apply only when `ctl_key_en`=1, `ctl_long`=1, the page user bit is 1 and `key_rights` is nonzero; otherwise they change nothing.
- R7: For key k, `key_rights` bit 2k set removes both read and write.
- R8: For key k, `key_rights` bit 2k+1 set, with bit 2k clear, removes write, but only for a user-mode access or when `ctl_wp`=1.
- R9: `acc_kind` encodes 0 = read, 1 = write, 2 = fetch, 3 = reserved. fault=1 exactly when the final right for the requested kind is 0 (rights are read, write, execute in that order); kind 3 always faults.
- R10: key_fault=1 exactly when the base rights grant the requested kind and the key rights remove it. Keys never remove execute, so a fetch never sets key_fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| pg_user | input | 1 | Accumulated page user bit |
| pg_write | input | 1 | Accumulated page writable bit |
| pg_noexec | input | 1 | Accumulated page no-execute bit |
| pg_key | input | KEY_BITS (4) | Protection key of the final entry |
| acc_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| acc_from_user | input | 1 | Access is made in user mode |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_smep | input | 1 | Block supervisor fetch from user pages |
| ctl_key_en | input | 1 | Protection keys enabled |
| ctl_long | input | 1 | Long mode active |
| key_rights | input | 2*2^KEY_BITS (32) | Per-key disable bits, two per key |
| out_valid | output | 1 | Result present this cycle |
| allow_rd | output | 1 | Final read right |
| allow_wr | output | 1 | Final write right |
| allow_ex | output | 1 | Final execute right |
| fault | output | 1 | Requested access is denied |
| key_fault | output | 1 | Denial caused only by the key rights |

## Verification
Each result is due one rising edge after its request is sampled. The bench drives requests on falling edges and reads results on the following falling edge, half a period after the register updates. The driver pushes each expected result into a queue as it applies the stimulus, and the monitor pops one entry whenever `out_valid` is high. Any `out_valid` with an empty queue, or an entry still left over at the end, shows that the one-cycle spacing was broken.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // rights vector positions; order matches the access-kind encoding
  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
  localparam int RT_EX = 2;

  typedef logic [2:0] rights_t;
endpackage

// File: rtl/ppc_base_rights.sv
module ppc_base_rights
  import ppc_pkg::*;
(
  input  logic    pg_user,
  input  logic    pg_write,
  input  logic    pg_noexec,
  input  logic    acc_from_user,
  input  logic    ctl_wp,
  input  logic    ctl_smep,
  output rights_t base
);
  logic user_block;

  always_comb begin
    user_block  = acc_from_user & ~pg_user;
    base[RT_RD] = 1'b1;
    base[RT_WR] = pg_write | (~acc_from_user & ~ctl_wp);
    base[RT_EX] = ~pg_noexec & (acc_from_user | ~(ctl_smep & pg_user));
    if (user_block) base = '0;
  end
endmodule

// File: rtl/ppc_key_rights.sv
module ppc_key_rights
  import ppc_pkg::*;
#(
  parameter int KEY_BITS = 4,
  localparam int NUM_KEYS = 1 << KEY_BITS,
  localparam int RIGHTS_W = 2 * NUM_KEYS
) (
  input  logic [KEY_BITS-1:0] pg_key,
  input  logic [RIGHTS_W-1:0] key_rights,
  input  logic                pg_user,
  input  logic                acc_from_user,
  input  logic                ctl_wp,
  input  logic                ctl_key_en,
  input  logic                ctl_long,
  output rights_t             key_mask
);
  logic [NUM_KEYS-1:0] acc_dis;
  logic [NUM_KEYS-1:0] wr_dis;
  logic                active;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign acc_dis[k] = key_rights[2*k];
    assign wr_dis[k]  = key_rights[2*k+1];
  end

  always_comb begin
    active   = ctl_key_en & ctl_long & pg_user & (|key_rights);
    key_mask = '1;
    if (active) begin
      if (acc_dis[pg_key]) begin
        key_mask[RT_RD] = 1'b0;
        key_mask[RT_WR] = 1'b0;
      end else if (wr_dis[pg_key] && (acc_from_user || ctl_wp)) begin
        key_mask[RT_WR] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppc_decide.sv
module ppc_decide
  import ppc_pkg::*;
(
  input  rights_t    base,
  input  rights_t    key_mask,
  input  logic [1:0] acc_kind,
  output rights_t    rights,
  output logic       fault,
  output logic       key_fault
);
  logic granted;
  logic base_ok;

  always_comb begin
    rights = base & key_mask;
    unique case (acc_kind_e'(acc_kind))
      ACC_READ:  begin granted = rights[RT_RD]; base_ok = base[RT_RD]; end
      ACC_WRITE: begin granted = rights[RT_WR]; base_ok = base[RT_WR]; end
      ACC_FETCH: begin granted = rights[RT_EX]; base_ok = base[RT_EX]; end
      default:   begin granted = 1'b0;          base_ok = 1'b0;          end
    endcase
    fault     = ~granted;
    key_fault = base_ok & ~granted;
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import ppc_pkg::*;
#(
  parameter int KEY_BITS = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                pg_user,
  input  logic                pg_write,
  input  logic                pg_noexec,
  input  logic [KEY_BITS-1:0] pg_key,
  input  logic [1:0]          acc_kind,
  input  logic                acc_from_user,
  input  logic                ctl_wp,
  input  logic                ctl_smep,
  input  logic                ctl_key_en,
  input  logic                ctl_long,
  input  logic [RIGHTS_W-1:0] key_rights,
  output logic                out_valid,
  output logic                allow_rd,
  output logic                allow_wr,
  output logic                allow_ex,
  output logic                fault,
  output logic                key_fault
);
  rights_t base, key_mask, rights_c;
  logic    fault_c, key_fault_c;

  ppc_base_rights i_base (
    .pg_user(pg_user), .pg_write(pg_write), .pg_noexec(pg_noexec),
    .acc_from_user(acc_from_user), .ctl_wp(ctl_wp), .ctl_smep(ctl_smep),
    .base(base)
  );

  ppc_key_rights #(.KEY_BITS(KEY_BITS)) i_key (
    .pg_key(pg_key), .key_rights(key_rights), .pg_user(pg_user),
    .acc_from_user(acc_from_user), .ctl_wp(ctl_wp),
    .ctl_key_en(ctl_key_en), .ctl_long(ctl_long), .key_mask(key_mask)
  );

  ppc_decide i_decide (
    .base(base), .key_mask(key_mask), .acc_kind(acc_kind),
    .rights(rights_c), .fault(fault_c), .key_fault(key_fault_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      allow_rd  <= 1'b0;
      allow_wr  <= 1'b0;
      allow_ex  <= 1'b0;
      fault     <= 1'b0;
      key_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        allow_rd  <= rights_c[RT_RD];
        allow_wr  <= rights_c[RT_WR];
        allow_ex  <= rights_c[RT_EX];
        fault     <= fault_c;
        key_fault <= key_fault_c;
      end
    end
  end
endmodule

// File: rtl/page_perm_check_sva.sv
module page_perm_check_sva #(
  parameter int KEY_BITS = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_BITS)
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                pg_user,
  input logic                pg_write,
  input logic                pg_noexec,
  input logic [KEY_BITS-1:0] pg_key,
  input logic [1:0]          acc_kind,
  input logic                acc_from_user,
  input logic                ctl_wp,
  input logic                ctl_smep,
  input logic                ctl_key_en,
  input logic                ctl_long,
  input logic [RIGHTS_W-1:0] key_rights,
  input logic                out_valid,
  input logic                allow_rd,
  input logic                allow_wr,
  input logic                allow_ex,
  input logic                fault,
  input logic                key_fault
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_user_block_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && acc_from_user && !pg_user |=>
      fault && !allow_rd && !allow_wr && !allow_ex && !key_fault);

  p_noexec_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && pg_noexec |=> !allow_ex);

  p_key_off_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && !(ctl_key_en && ctl_long) |=> !key_fault);

  p_rsvd_kind_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && acc_kind == 2'd3 |=> fault && !key_fault);

  p_fetch_no_key_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid && acc_kind == 2'd2 |=> !key_fault);

  p_key_implies_fault_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && key_fault |-> fault);

  // pg_key, pg_write, ctl_wp, ctl_smep and key_rights feed only the
  // per-value rules checked by the bench scoreboard
  logic unused_ok;
  assign unused_ok = ^{pg_key, pg_write, ctl_wp, ctl_smep, key_rights};
endmodule

bind page_perm_check page_perm_check_sva #(.KEY_BITS(KEY_BITS)) i_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pg_user(pg_user),
  .pg_write(pg_write), .pg_noexec(pg_noexec), .pg_key(pg_key),
  .acc_kind(acc_kind), .acc_from_user(acc_from_user), .ctl_wp(ctl_wp),
  .ctl_smep(ctl_smep), .ctl_key_en(ctl_key_en), .ctl_long(ctl_long),
  .key_rights(key_rights), .out_valid(out_valid), .allow_rd(allow_rd),
  .allow_wr(allow_wr), .allow_ex(allow_ex), .fault(fault),
  .key_fault(key_fault)
);

// File: tb/test_page_perm_check.sv
module test_page_perm_check;
  localparam int KB = 4;
  localparam int RW = 2 * (1 << KB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic pg_user = 1'b0, pg_write = 1'b0, pg_noexec = 1'b0;
  logic [KB-1:0] pg_key = '0;
  logic [1:0] acc_kind = '0;
  logic acc_from_user = 1'b0, ctl_wp = 1'b0, ctl_smep = 1'b0;
  logic ctl_key_en = 1'b0, ctl_long = 1'b0;
  logic [RW-1:0] key_rights = '0;
  logic out_valid, allow_rd, allow_wr, allow_ex, fault, key_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic rd, wr, ex, flt, kf;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  page_perm_check #(.KEY_BITS(KB)) i_page_perm_check (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pg_user(pg_user),
    .pg_write(pg_write), .pg_noexec(pg_noexec), .pg_key(pg_key),
    .acc_kind(acc_kind), .acc_from_user(acc_from_user), .ctl_wp(ctl_wp),
    .ctl_smep(ctl_smep), .ctl_key_en(ctl_key_en), .ctl_long(ctl_long),
    .key_rights(key_rights), .out_valid(out_valid), .allow_rd(allow_rd),
    .allow_wr(allow_wr), .allow_ex(allow_ex), .fault(fault),
    .key_fault(key_fault)
  );

  // expected result from the requirements
  function automatic exp_t model(logic u, logic w, logic nx, logic [KB-1:0] k,
                                 logic [1:0] kind, logic usr, logic wp,
                                 logic smep, logic ken, logic lm,
                                 logic [RW-1:0] kr);
    exp_t e;
    logic [2:0] b, f;  // bit0 read, bit1 write, bit2 execute
    logic base_ok, ok;
    if (usr && !u) begin
      e = '0; e.flt = 1'b1; return e;  // R2
    end
    b[0] = 1'b1;                                  // R3
    b[1] = w || (!usr && !wp);                    // R4
    b[2] = !nx && !(smep && !usr && u);           // R5
    f = b;
    if (ken && lm && u && (kr != 0)) begin        // R6
      if (kr[2*k]) f[1:0] = 2'b00;                // R7
      else if (kr[2*k+1] && (usr || wp)) f[1] = 1'b0;  // R8
    end
    ok      = (kind == 2'd3) ? 1'b0 : f[kind];    // R9
    base_ok = (kind == 2'd3) ? 1'b0 : b[kind];
    e.rd = f[0]; e.wr = f[1]; e.ex = f[2];
    e.flt = !ok;
    e.kf  = base_ok && !ok;                       // R10
    return e;
  endfunction

  task automatic drive(string tag, logic u, logic w, logic nx,
                       logic [KB-1:0] k, logic [1:0] kind, logic usr,
                       logic wp, logic smep, logic ken, logic lm,
                       logic [RW-1:0] kr);
    @(negedge clk);
    in_valid = 1'b1; pg_user = u; pg_write = w; pg_noexec = nx; pg_key = k;
    acc_kind = kind; acc_from_user = usr; ctl_wp = wp; ctl_smep = smep;
    ctl_key_en = ken; ctl_long = lm; key_rights = kr;
    exp_q.push_back(model(u, w, nx, k, kind, usr, wp, smep, ken, lm, kr));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: results are sampled on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        exp_t  e;
        exp_t  a;
        string t;
        a = '{allow_rd, allow_wr, allow_ex, fault, key_fault};
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected out_valid, act=%b exp=none", a);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (a !== e) begin
            errors++;
            $display("FAIL %s: {rd,wr,ex,fault,kf} act=%b exp=%b", t, a, e);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] kr5;
    // R1 reset: valid input during reset must not show up
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, allow_rd, allow_wr, allow_ex, fault, key_fault} !== 6'b0) begin
      errors++;
      $display("FAIL R1: reset outputs act=%b exp=000000",
               {out_valid, allow_rd, allow_wr, allow_ex, fault, key_fault});
    end
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    kr5 = '0; kr5[10] = 1'b1;  // key 5 access-disable
    // args: tag, u, w, nx, key, kind, usr, wp, smep, ken, lm, rights
    drive("R2", 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, '0);
    drive("R2", 0, 1, 0, 5, 2, 1, 1, 1, 1, 1, kr5);
    drive("R3", 1, 0, 1, 0, 0, 1, 1, 0, 0, 0, '0);
    drive("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, '0);
    drive("R4", 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, '0);
    drive("R4", 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, '0);
    drive("R5", 1, 1, 1, 0, 2, 1, 0, 0, 0, 0, '0);
    drive("R5", 1, 1, 0, 0, 2, 0, 0, 1, 0, 0, '0);
    drive("R5", 0, 1, 0, 0, 2, 0, 0, 1, 0, 0, '0);
    drive("R5", 1, 1, 0, 0, 2, 1, 0, 1, 0, 0, '0);
    drive("R7", 1, 1, 0, 5, 0, 1, 0, 0, 1, 1, kr5);
    drive("R10", 1, 1, 0, 5, 2, 1, 0, 0, 1, 1, kr5);
    drive("R6", 1, 1, 0, 5, 0, 1, 0, 0, 0, 1, kr5);
    drive("R6", 1, 1, 0, 5, 0, 1, 0, 0, 1, 0, kr5);
    drive("R6", 0, 1, 0, 5, 0, 0, 0, 0, 1, 1, kr5);
    drive("R7", 1, 1, 0, 4, 0, 1, 0, 0, 1, 1, kr5);
    drive("R8", 1, 1, 0, 7, 1, 1, 0, 0, 1, 1, 32'h0000_8000);
    drive("R8", 1, 1, 0, 7, 1, 0, 0, 0, 1, 1, 32'h0000_8000);
    drive("R8", 1, 1, 0, 7, 1, 0, 1, 0, 1, 1, 32'h0000_8000);
    drive("R8", 1, 1, 0, 15, 0, 1, 1, 0, 1, 1, 32'h8000_0000);
    drive("R10", 1, 1, 0, 15, 1, 1, 1, 0, 1, 1, 32'h8000_0000);
    drive("R10", 1, 0, 0, 15, 1, 1, 1, 0, 1, 1, 32'h8000_0000);
    drive("R9", 1, 1, 0, 0, 3, 1, 0, 0, 0, 0, '0);
    drive("R9", 1, 1, 0, 0, 3, 0, 0, 0, 1, 1, '1);
    idle();
    idle();
    // R1: no result while idle
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid while idle act=%b exp=0", out_valid);
    end

    for (int i = 0; i < 400; i++) begin
      logic [RW-1:0] kr;
      kr = ($urandom % 4 == 0) ? '0 : RW'($urandom);
      drive("R9", 1'($urandom), 1'($urandom), 1'($urandom), KB'($urandom),
            2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom % 4 != 0), 1'($urandom % 4 != 0), kr);
      if ($urandom % 5 == 0) idle();
    end
    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: results missing act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule